// File: doc/BRIEF.md
# Pipelined Table-Driven Floating-Point Square Root

This unit takes one single-precision floating-point operand per clock and returns its square root a fixed number of cycles later. A strobe travels with each operand and comes out as a completion strobe. An exception flag travels the same way and marks results that are not valid. Operands are expected to be normalized positive values; rounding and renormalization of the result are left to a later stage.

The significand is processed in three phases. First, a table indexed by the leading significand bits supplies an approximate reciprocal R, so that A = Y·R − 1 becomes a small signed value. Second, sqrt(1+A) is approximated by a short Taylor polynomial built from narrow products of A's top chunks. Third, the polynomial is scaled by a second table value M = 1/sqrt(R), or sqrt(2/R) when the unbiased exponent is odd. The exponent path halves the unbiased exponent after making it even and then adds the bias back.

Top module: `fsqrt_pipe`

## Requirements
- R1: While `rst` is high, `done` and `exc_out` go low on the next clock edge.
- R2: `done` rises exactly LATENCY cycles (default 14) after the cycle in which `go` was high. A new operand may be given on every cycle, and results come out in the order the operands went in.
- R3: For an operand with sign bit 31 = 0 and exponent field bits 30:23 in 1..254 (bias 127, fraction in bits 22:0), `root` has sign 0 and a nonzero exponent field. Its value is within a relative error of 8·2^-23 of the exact square root.
- R4: R3 holds for odd unbiased exponents as well as even ones, including operands just below an exact power of four.
- R5: An operand with exponent field 0 is treated as zero. `root` then has a zero magnitude (bits 30:0), keeps the operand's sign bit, and `exc_out` stays low.
- R6: An operand with sign bit 1 and a nonzero exponent field raises `exc_out` together with `done`, and `root` is all zeros.
- R7: `exc_in` given with `go` comes out as `exc_out` together with that operand's `done`, and `root` is then all zeros.
- R8: `done` never pulses in a cycle that does not belong to an accepted operand. `exc_out` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Operand on `x_in` is valid this cycle |
| exc_in | input | 1 | Upstream exception for this operand |
| x_in | input | 32 | Operand: sign, biased exponent, fraction |
| done | output | 1 | Result on `root` is valid this cycle |
| exc_out | output | 1 | Result is flagged as an exception |
| root | output | 32 | Square root in the same format |

## Verification
Random positive operands over the whole exponent range exercise table entries in both exponent-parity halves and are measured against an exact real square root. Directed operands then target specific cases. Values 1, 2 and 4 separate the even and odd exponent handling. A significand just below 2 with an odd exponent pushes the postprocessing product to its ceiling near 2.0. Smallest and largest normals stress the exponent halving. Signed zeros, negative values and upstream exceptions are mixed into a stream with random gaps, which shows whether each flag stays attached to its own operand and whether bubbles ever produce a completion.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;

    // Operand format
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD   = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    // Chunk width k and derived fixed-point scales
    localparam int K     = (FRAC_W + 4) / 4;
    localparam int N     = 4 * K;              // significand width
    localparam int PAD   = N - FRAC_W - 1;
    localparam int RF    = 2 * K - 2;          // fraction bits of R
    localparam int RW    = RF + 1;
    localparam int AF    = N - 1 + RF;         // fraction bits of A
    localparam int AW    = AF + 3;
    localparam int HSH   = AF - 2 * K;         // A2 chunk position
    localparam int HW    = K + 3;
    localparam int CW    = HW + K + 1;
    localparam int BF    = AF + 1;             // fraction bits of B
    localparam int BW    = BF + 3;
    localparam int SQ_SH = BF - 4 * K - 3;
    localparam int CR_SH = BF - 5 * K - 2;
    localparam int MF    = N + 6;              // fraction bits of M
    localparam int MW    = MF + 1;
    localparam int PRW   = BW + MW + 1;
    localparam int NR    = 1 << (K - 1);       // R table entries
    localparam int NM    = 1 << K;             // M table entries
    localparam int BASE_LAT = 6;

    typedef struct packed {
        logic             vld;
        logic             exc;
        logic             zero;
        logic             sgn;
        logic [EXP_W-1:0] ex;
    } side_t;

    typedef struct packed {
        logic            done;
        logic            exc;
        logic [WORD-1:0] root;
    } res_t;

    // R entry: rounded reciprocal of the interval midpoint
    function automatic int r_entry(input int f);
        int num;
        int den;
        num = 1 << (RF + K);
        den = (1 << K) + 2 * f + 1;
        return (2 * num / den + 1) / 2;
    endfunction

    function automatic logic [127:0] isqrt(input logic [127:0] v);
        logic [127:0] res;
        logic [127:0] cand;
        res = '0;
        for (int b = 63; b >= 0; b--) begin
            cand = res | (128'(1) << b);
            if (cand * cand <= v) res = cand;
        end
        return res;
    endfunction

    // M entry: 1/sqrt(R), or sqrt(2/R) for the odd-exponent half
    function automatic logic [127:0] m_entry(input int idx);
        int           odd;
        int           r;
        logic [127:0] v;
        odd = idx >> (K - 1);
        r   = r_entry(idx & (NR - 1));
        v   = (128'(1) << (2 * MF + RF)) << odd;
        return isqrt(v / 128'(r));
    endfunction

endpackage

// File: rtl/fsqrt_reduce.sv
module fsqrt_reduce
    import fsqrt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic                 exc_in,
    input  logic [WORD-1:0]      x_in,
    output side_t                side_o,
    output logic signed [AW-1:0] a_o,
    output logic [MW-1:0]        m_o
);

    localparam logic signed [AW-1:0] ONE_A = {{(AW-AF-1){1'b0}}, 1'b1, {AF{1'b0}}};

    logic [RW-1:0] r_tab [NR];
    logic [MW-1:0] m_tab [NM];

    for (genvar gi = 0; gi < NR; gi++) begin : g_rtab
        assign r_tab[gi] = RW'(r_entry(gi));
    end
    for (genvar gj = 0; gj < NM; gj++) begin : g_mtab
        assign m_tab[gj] = MW'(m_entry(gj));
    end

    // Operand decode and exponent halving
    logic                     sgn;
    logic [EXP_W-1:0]         ex_f;
    logic [FRAC_W-1:0]        frac;
    logic                     zero;
    logic                     neg;
    logic signed [EXP_W+1:0]  eu;
    logic signed [EXP_W+1:0]  hf;
    logic                     odd;
    logic [K-2:0]             f_top;
    side_t                    side_n;

    always_comb begin
        sgn   = x_in[WORD-1];
        ex_f  = EXP_W'(x_in >> FRAC_W);
        frac  = FRAC_W'(x_in);
        zero  = (ex_f == '0);
        neg   = sgn & ~zero;
        eu    = $signed({2'b00, ex_f}) - $signed((EXP_W+2)'(BIAS));
        odd   = eu[0];
        hf    = (eu - $signed({{(EXP_W+1){1'b0}}, odd})) >>> 1;
        f_top = (K-1)'(frac >> (FRAC_W - K + 1));
        side_n.vld  = go;
        side_n.exc  = go & (exc_in | neg);
        side_n.zero = zero;
        side_n.sgn  = sgn;
        side_n.ex   = EXP_W'(hf + $signed((EXP_W+2)'(BIAS)));
    end

    // Stage A: significand, R lookup, M index
    side_t         side_a;
    logic [N-1:0]  y_a;
    logic [RW-1:0] r_a;
    logic [K-1:0]  mi_a;

    always_ff @(posedge clk) begin
        if (rst) side_a <= '0;
        else     side_a <= side_n;
    end

    always_ff @(posedge clk) begin
        y_a  <= N'({1'b1, frac}) << PAD;
        r_a  <= r_tab[f_top];
        mi_a <= {odd, f_top};
    end

    // Stage B: A = Y*R - 1, M lookup
    logic [N+RW-1:0] p_b;
    always_comb p_b = (N+RW)'(y_a) * (N+RW)'(r_a);

    always_ff @(posedge clk) begin
        if (rst) side_o <= '0;
        else     side_o <= side_a;
    end

    always_ff @(posedge clk) begin
        a_o <= $signed(AW'(p_b)) - ONE_A;
        m_o <= m_tab[mi_a];
    end

endmodule

// File: rtl/fsqrt_eval.sv
module fsqrt_eval
    import fsqrt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  side_t                side_i,
    input  logic signed [AW-1:0] a_i,
    input  logic [MW-1:0]        m_i,
    output side_t                side_o,
    output logic signed [BW-1:0] b_o,
    output logic [MW-1:0]        m_o
);

    localparam logic signed [BW-1:0] ONE_B = {{(BW-BF-1){1'b0}}, 1'b1, {BF{1'b0}}};

    // Split A into its top signed chunk and the following chunk
    logic signed [HW-1:0]   a_hi;
    logic [K-1:0]           a_mid;
    logic signed [2*HW-1:0] sq_n;
    logic signed [CW-1:0]   cr_n;

    always_comb begin
        a_hi  = HW'(a_i >>> HSH);
        a_mid = K'(a_i >> (HSH - K));
        sq_n  = (2*HW)'(a_hi) * (2*HW)'(a_hi);
        cr_n  = CW'(a_hi) * CW'($signed({1'b0, a_mid}));
    end

    // Stage C: small products
    side_t                  side_c;
    logic signed [AW-1:0]   a_c;
    logic signed [2*HW-1:0] sq_c;
    logic signed [CW-1:0]   cr_c;
    logic [MW-1:0]          m_c;

    always_ff @(posedge clk) begin
        if (rst) side_c <= '0;
        else     side_c <= side_i;
    end

    always_ff @(posedge clk) begin
        a_c  <= a_i;
        sq_c <= sq_n;
        cr_c <= cr_n;
        m_c  <= m_i;
    end

    // Stage D: multi-operand signed sum B = 1 + A/2 - A^2/8
    always_ff @(posedge clk) begin
        if (rst) side_o <= '0;
        else     side_o <= side_c;
    end

    always_ff @(posedge clk) begin
        b_o <= ONE_B + BW'(a_c) - (BW'(sq_c) <<< SQ_SH) - (BW'(cr_c) <<< CR_SH);
        m_o <= m_c;
    end

endmodule

// File: rtl/fsqrt_post.sv
module fsqrt_post
    import fsqrt_pkg::*;
#(
    parameter int LATENCY = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  side_t                side_i,
    input  logic signed [BW-1:0] b_i,
    input  logic [MW-1:0]        m_i,
    output logic                 done,
    output logic                 exc_out,
    output logic [WORD-1:0]      root
);

    localparam int EXTRA = (LATENCY > BASE_LAT) ? LATENCY - BASE_LAT : 0;

    // Stage E: B * M
    side_t                 side_e;
    logic signed [PRW-1:0] prod_e;

    always_ff @(posedge clk) begin
        if (rst) side_e <= '0;
        else     side_e <= side_i;
    end

    always_ff @(posedge clk) begin
        prod_e <= PRW'(b_i) * PRW'($signed({1'b0, m_i}));
    end

    // Stage F: pack the result
    logic [FRAC_W-1:0]     frac;
    logic signed [PRW-1:0] hi;
    logic                  sat;
    res_t                  res_n;
    res_t                  res_f;
    res_t                  res_q;

    always_comb begin
        frac = FRAC_W'(prod_e >> (BF + MF - FRAC_W));
        hi   = prod_e >>> (BF + MF + 1);
        sat  = (hi != '0);
        res_n.done = side_e.vld;
        res_n.exc  = side_e.exc;
        if (side_e.exc)
            res_n.root = '0;
        else if (side_e.zero)
            res_n.root = {side_e.sgn, {(WORD-1){1'b0}}};
        else
            res_n.root = {1'b0, side_e.ex, sat ? {FRAC_W{1'b1}} : frac};
    end

    always_ff @(posedge clk) begin
        if (rst) res_f <= '0;
        else     res_f <= res_n;
    end

    // Retiming stages up to the configured latency
    if (EXTRA == 0) begin : g_direct
        assign res_q = res_f;
    end else begin : g_delay
        res_t dl [EXTRA];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < EXTRA; i++) dl[i] <= '0;
            end else begin
                dl[0] <= res_f;
                for (int i = 1; i < EXTRA; i++) dl[i] <= dl[i-1];
            end
        end
        assign res_q = dl[EXTRA-1];
    end

    assign done    = res_q.done;
    assign exc_out = res_q.exc;
    assign root    = res_q.root;

endmodule

// File: rtl/fsqrt_pipe.sv
module fsqrt_pipe
    import fsqrt_pkg::*;
#(
    parameter int LATENCY = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            exc_in,
    input  logic [WORD-1:0] x_in,
    output logic            done,
    output logic            exc_out,
    output logic [WORD-1:0] root
);

    side_t                side_b;
    side_t                side_d;
    logic signed [AW-1:0] a_b;
    logic [MW-1:0]        m_b;
    logic signed [BW-1:0] b_d;
    logic [MW-1:0]        m_d;

    fsqrt_reduce u_reduce (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .exc_in (exc_in),
        .x_in   (x_in),
        .side_o (side_b),
        .a_o    (a_b),
        .m_o    (m_b)
    );

    fsqrt_eval u_eval (
        .clk    (clk),
        .rst    (rst),
        .side_i (side_b),
        .a_i    (a_b),
        .m_i    (m_b),
        .side_o (side_d),
        .b_o    (b_d),
        .m_o    (m_d)
    );

    fsqrt_post #(.LATENCY(LATENCY)) u_post (
        .clk     (clk),
        .rst     (rst),
        .side_i  (side_d),
        .b_i     (b_d),
        .m_i     (m_d),
        .done    (done),
        .exc_out (exc_out),
        .root    (root)
    );

endmodule

// File: rtl/fsqrt_chk.sv
module fsqrt_chk
    import fsqrt_pkg::*;
#(
    parameter int LATENCY = 14
) (
    input logic            clk,
    input logic            rst,
    input logic            go,
    input logic            exc_in,
    input logic [WORD-1:0] x_in,
    input logic            done,
    input logic            exc_out,
    input logic [WORD-1:0] root
);

    localparam int L = (LATENCY > BASE_LAT) ? LATENCY : BASE_LAT;

    logic [EXP_W-1:0] ex_f;
    logic             zin;
    logic             neg;
    logic [L-1:0]     go_sh;
    logic [L-1:0]     exc_sh;
    logic [L-1:0]     zero_sh;
    logic [L-1:0]     sgn_sh;

    always_comb begin
        ex_f = EXP_W'(x_in >> FRAC_W);
        zin  = (ex_f == '0);
        neg  = x_in[WORD-1] & ~zin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go_sh   <= '0;
            exc_sh  <= '0;
            zero_sh <= '0;
            sgn_sh  <= '0;
        end else begin
            go_sh   <= {go_sh[L-2:0], go};
            exc_sh  <= {exc_sh[L-2:0], go & (exc_in | neg)};
            zero_sh <= {zero_sh[L-2:0], zin};
            sgn_sh  <= {sgn_sh[L-2:0], x_in[WORD-1]};
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && !exc_out));

    // R2, R8
    a_r2_done_latency: assert property (@(posedge clk) disable iff (rst)
        done == go_sh[L-1]);

    // R7, R6
    a_r7_exc_follows: assert property (@(posedge clk) disable iff (rst)
        exc_out == exc_sh[L-1]);

    // R8
    a_r8_exc_needs_done: assert property (@(posedge clk) disable iff (rst)
        exc_out |-> done);

    // R6, R7
    a_r6_exc_clears_root: assert property (@(posedge clk) disable iff (rst)
        exc_out |-> (root == '0));

    // R5
    a_r5_zero_out: assert property (@(posedge clk) disable iff (rst)
        (done && zero_sh[L-1] && !exc_sh[L-1]) |->
            ((root << 1) == '0 && root[WORD-1] == sgn_sh[L-1]));

    // R3
    a_r3_positive_normal: assert property (@(posedge clk) disable iff (rst)
        (done && !zero_sh[L-1] && !exc_sh[L-1]) |->
            (!root[WORD-1] && root[WORD-2 -: EXP_W] != '0));

endmodule

bind fsqrt_pipe fsqrt_chk #(.LATENCY(LATENCY)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .exc_in  (exc_in),
    .x_in    (x_in),
    .done    (done),
    .exc_out (exc_out),
    .root    (root)
);

// File: tb/test_fsqrt_pipe.sv
module test_fsqrt_pipe;

    localparam int LAT   = 14;
    localparam int LIMIT = 60000;
    localparam real TOL  = 8.0 / 8388608.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic        exc_in = 1'b0;
    logic [31:0] x_in = '0;
    logic        done;
    logic        exc_out;
    logic [31:0] root;

    fsqrt_pipe #(.LATENCY(LAT)) i_fsqrt_pipe (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .exc_in  (exc_in),
        .x_in    (x_in),
        .done    (done),
        .exc_out (exc_out),
        .root    (root)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [31:0] x;
        logic        e;
        int          c;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    ended = 0;

    function automatic real fval(input logic [31:0] w);
        real m;
        m = 1.0 + real'(w[22:0]) / 8388608.0;
        return m * $pow(2.0, real'(int'(w[30:23]) - 127));
    endfunction

    task automatic finish_run();
        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic check_item(input item_t it);
        bit  zero;
        bit  neg;
        real s;
        real r;
        real rel;
        zero = (it.x[30:23] == 8'd0);
        neg  = it.x[31] && !zero;
        // R2: exact latency and in-order delivery
        n_run++;
        if (cyc != it.c + LAT) begin
            n_fail++;
            $display("FAIL R2 x=%h latency got %0d expected %0d", it.x, cyc - it.c, LAT);
        end
        n_run++;
        if (it.e) begin
            // R7: upstream exception rides along, root cleared
            if (!exc_out || root != 32'd0) begin
                n_fail++;
                $display("FAIL R7 x=%h got exc=%0b root=%h expected exc=1 root=00000000",
                         it.x, exc_out, root);
            end
        end else if (neg) begin
            // R6: negative nonzero operand
            if (!exc_out || root != 32'd0) begin
                n_fail++;
                $display("FAIL R6 x=%h got exc=%0b root=%h expected exc=1 root=00000000",
                         it.x, exc_out, root);
            end
        end else if (zero) begin
            // R5: zero keeps its sign
            if (exc_out || root != {it.x[31], 31'd0}) begin
                n_fail++;
                $display("FAIL R5 x=%h got exc=%0b root=%h expected exc=0 root=%h",
                         it.x, exc_out, root, {it.x[31], 31'd0});
            end
        end else begin
            s = $sqrt(fval(it.x));
            r = fval(root);
            rel = (r > s) ? (r - s) / s : (s - r) / s;
            if (exc_out || root[31] || root[30:23] == 8'd0 || rel > TOL) begin
                n_fail++;
                if (((int'(it.x[30:23]) - 127) % 2) != 0)
                    $display("FAIL R4 odd x=%h got root=%h (%g) exc=%0b expected %g",
                             it.x, root, r, exc_out, s);
                else
                    $display("FAIL R3 x=%h got root=%h (%g) exc=%0b expected %g",
                             it.x, root, r, exc_out, s);
            end
        end
    endtask

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst && !ended && done) begin
            if (q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL R8 spurious done root=%h exc=%0b expected no done", root, exc_out);
            end else begin
                check_item(q.pop_front());
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > LIMIT && !ended) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog after %0d cycles, expected completion", cyc);
            finish_run();
        end
    end

    task automatic send(input logic [31:0] x, input logic e);
        @(negedge clk);
        go     = 1'b1;
        exc_in = e;
        x_in   = x;
        q.push_back('{x: x, e: e, c: cyc});
    endtask

    task automatic idle();
        @(negedge clk);
        go     = 1'b0;
        exc_in = 1'b0;
        x_in   = $urandom;
    endtask

    logic [31:0] directed [12] = '{
        32'h3F800000,   // 1.0, even exponent
        32'h40000000,   // 2.0, odd exponent
        32'h40800000,   // 4.0
        32'h3FFFFFFF,   // just below 2
        32'h407FFFFF,   // just below 4, odd: ceiling of the product
        32'h00800000,   // smallest normal
        32'h7F7FFFFF,   // largest finite
        32'h00000000,   // +0
        32'h80000000,   // -0
        32'hC0800000,   // -4
        32'h3E800000,   // 0.25
        32'h41100000    // 9.0
    };

    initial begin
        void'($urandom(32'd20240517));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_run++;
        if (done !== 1'b0 || exc_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 got done=%b exc=%b expected done=0 exc=0", done, exc_out);
        end
        @(negedge clk);
        rst = 1'b0;
        idle();

        // Directed corners, back to back
        for (int i = 0; i < 12; i++) send(directed[i], 1'b0);
        send(32'h40490FDB, 1'b1);   // R7 with a positive operand
        send(32'hBF800000, 1'b1);   // R7 with a negative operand
        idle();

        // Random stream with gaps
        for (int n = 0; n < 600; n++) begin
            logic [31:0] x;
            logic        e;
            int          cls;
            cls = int'($urandom % 16);
            e   = 1'b0;
            if (cls == 0)      x = {$urandom % 2 == 0 ? 1'b0 : 1'b1, 8'd0, 23'($urandom)};
            else if (cls == 1) x = {1'b1, 8'(1 + $urandom % 254), 23'($urandom)};
            else begin
                x = {1'b0, 8'(1 + $urandom % 254), 23'($urandom)};
                if (cls == 2) e = 1'b1;
            end
            send(x, e);
            if ($urandom % 5 == 0) idle();
        end
        idle();

        // Drain and confirm every operand completed (R2)
        for (int w = 0; w < 4 * LAT && q.size() != 0; w++) idle();
        repeat (LAT + 2) idle();
        n_run++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 %0d results missing, expected 0", q.size());
        end
        finish_run();
    end

endmodule